// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit takes two 32-bit operands and returns one 32-bit result. A 2-bit opcode selects one of four functions. Two of them are compares in the style of a processor, where the result is the difference `b - a` and its top bit is then patched so that it shows the ordering of the operands. The third is the carry-out of `a + b + cin`, returned in bit 0. The fourth is a byte-lane search that gives the 1-based position of the first equal byte, scanning down from the most significant lane.

An execution stage feeds the unit with operands, an opcode and a valid strobe. The parameter `OUT_REG` selects between a purely combinational path (0) and a single output register that adds one cycle of latency (1). Register access, flag storage and instruction decode are handled outside the unit.

Top module: `cmp_bytematch_unit`

## Requirements
- R1: With opcode 2'b00 (signed compare) and equal operand MSBs, the result is `opb + ~opa + 1` (the wrap-around difference) with no bits changed.
- R2: With opcode 2'b00 and different operand MSBs, bits 30:0 of the result are taken from the difference and bit 31 equals `opb[31]`.
- R3: With opcode 2'b01 (unsigned compare), the result is the difference. When the operand MSBs differ, bit 31 is replaced by `opa[31]`.
- R4: With opcode 2'b10 (carry), bits 31:1 of the result are zero. Bit 0 is 1 when `opb` is all ones and `cin` is 1. In every other case bit 0 is 1 exactly when `(32'hFFFFFFFF - opa) < (opb + cin)`.
- R5: With opcode 2'b11 (byte search), the result is 1, 2, 3 or 4 for the first equal lane, checked in the order bits 31:24, 23:16, 15:8, 7:0.
- R6: With opcode 2'b11 and no equal byte lane, the result is 0.
- R7: When `OUT_REG` is 0, `result` and `out_valid` follow the inputs in the same cycle. When `OUT_REG` is 1, they appear one clock after `in_valid`. While `in_valid` is low, the registered `result` holds its value and `out_valid` is 0.
- R8: When `OUT_REG` is 1, a synchronous active-low reset clears `result` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used only when OUT_REG=1) |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid |
| op | input | 2 | 00 signed cmp, 01 unsigned cmp, 10 carry, 11 byte search |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b |
| cin | input | 1 | Carry-in for the carry function |
| result | output | 32 | Selected result |
| out_valid | output | 1 | Result is valid |

## Verification
The bench drives each stimulus on a falling edge into two instances at once. In the combinational instance, the result and valid are due in the same cycle, so they are checked a few nanoseconds after the drive and before the next rising edge. In the registered instance, they are due one rising edge later, so they are checked on the following falling edge, after the single register has loaded. A cycle with `in_valid` low is also checked one edge later to confirm that the registered result holds its value and the valid drops.

// File: rtl/cmpu_pkg.sv
// Package: shared opcode type for the compare / byte-match unit.
package cmpu_pkg;

    typedef enum logic [1:0] {
        OP_SCMP  = 2'b00,
        OP_UCMP  = 2'b01,
        OP_CARRY = 2'b10,
        OP_BYTE  = 2'b11
    } cmpu_op_e;

endpackage

// File: rtl/cmpu_order_cmp.sv
// Module: cmpu_order_cmp
// Forms b - a in wrap-around arithmetic. When the operand MSBs differ, the
// MSB of that difference is overwritten: by b's MSB for the signed form and
// by a's MSB for the unsigned form. Assumes WIDTH >= 2. Purely combinational.
module cmpu_order_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_unsigned,
    output logic [WIDTH-1:0] res
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] diff;
    logic             sign_split;

    // Difference and MSB disagreement detection.
    always_comb begin
        diff       = b + ~a + {{(WIDTH-1){1'b0}}, 1'b1};
        sign_split = a[MSB] ^ b[MSB];
    end

    // Patch the top bit when the operand signs disagree.
    always_comb begin
        res = diff;
        if (sign_split) begin
            res[MSB] = is_unsigned ? a[MSB] : b[MSB];
        end
    end
endmodule

// File: rtl/cmpu_carry.sv
// Module: cmpu_carry
// Carry-out of a + b + cin, produced by one extended-width add.
// Purely combinational.
module cmpu_carry #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic             cout
);
    logic [WIDTH:0] sum_ext;

    // Add with one guard bit; the guard bit is the carry.
    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        cout    = sum_ext[WIDTH];
    end
endmodule

// File: rtl/cmpu_byte_scan.sv
// Module: cmpu_byte_scan
// Compares a and b lane by lane and returns the 1-based index of the first
// equal lane, counting from the most significant lane. Returns 0 when no lane
// matches. Assumes WIDTH is a multiple of LANE_W. Combinational.
module cmpu_byte_scan #(
    parameter int WIDTH  = 32,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [IDX_W-1:0] idx
);
    localparam int LANES = WIDTH / LANE_W;

    logic [LANES-1:0] lane_eq;   // bit k: k-th lane counted from the MSB end

    // One equality comparator per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = WIDTH - 1 - k * LANE_W;
        assign lane_eq[k] = (a[HI -: LANE_W] == b[HI -: LANE_W]);
    end

    // Priority pick: the lane nearest the MSB wins.
    always_comb begin
        idx = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (lane_eq[k]) begin
                idx = IDX_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/cmp_bytematch_unit.sv
// Module: cmp_bytematch_unit (top)
// Selects signed compare, unsigned compare, carry-out or byte search with a
// 2-bit opcode. OUT_REG=0 gives a combinational output. OUT_REG=1 adds one
// register stage that loads on in_valid and is cleared by a synchronous
// active-low reset.
module cmp_bytematch_unit #(
    parameter int WIDTH   = 32,
    parameter int LANE_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] result,
    output logic             out_valid
);
    import cmpu_pkg::*;

    localparam int LANES = WIDTH / LANE_W;
    localparam int IDX_W = $clog2(LANES + 1);

    cmpu_op_e         op_e;
    logic [WIDTH-1:0] cmp_res;
    logic             carry_bit;
    logic [IDX_W-1:0] lane_idx;
    logic [WIDTH-1:0] comb_res;

    assign op_e = cmpu_op_e'(op);

    cmpu_order_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a           (opa),
        .b           (opb),
        .is_unsigned (op_e == OP_UCMP),
        .res         (cmp_res)
    );

    cmpu_carry #(.WIDTH(WIDTH)) u_carry (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .cout (carry_bit)
    );

    cmpu_byte_scan #(.WIDTH(WIDTH), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_scan (
        .a   (opa),
        .b   (opb),
        .idx (lane_idx)
    );

    // Result select by opcode.
    always_comb begin
        unique case (op_e)
            OP_SCMP, OP_UCMP: comb_res = cmp_res;
            OP_CARRY:         comb_res = {{(WIDTH-1){1'b0}}, carry_bit};
            default:          comb_res = {{(WIDTH-IDX_W){1'b0}}, lane_idx};
        endcase
    end

    if (OUT_REG) begin : g_reg
        logic [WIDTH-1:0] res_q;
        logic             vld_q;

        // Output stage: load on valid, hold otherwise, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= comb_res;
                end
            end
        end

        assign result    = res_q;
        assign out_valid = vld_q;
    end else begin : g_comb
        assign result    = comb_res;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/cmpu_checker.sv
// Module: cmpu_checker
// Assertions for cmp_bytematch_unit, attached with bind. Observes the ports
// and the internal combinational result selected before the output stage.
module cmpu_checker #(
    parameter int WIDTH   = 32,
    parameter int LANE_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] comb_res,
    input logic [WIDTH-1:0] result,
    input logic             out_valid
);
    localparam int MSB   = WIDTH - 1;
    localparam int LANES = WIDTH / LANE_W;

    // R2: signed compare, split signs -> top bit from b
    p_sign_from_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00 && (opa[MSB] != opb[MSB])) |-> (comb_res[MSB] == opb[MSB]));

    // R3: unsigned compare, split signs -> top bit from a
    p_sign_from_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && (opa[MSB] != opb[MSB])) |-> (comb_res[MSB] == opa[MSB]));

    // R4: carry result is zero-extended
    p_carry_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10) |-> (comb_res[MSB:1] == '0));

    // R5: byte search index stays within lane count
    p_lane_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11) |-> (comb_res <= WIDTH'(LANES)));

    if (OUT_REG) begin : g_reg_chk
        // R7: registered output one cycle after in_valid
        p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && result == $past(comb_res)));

        // R7: result held while no new input
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result)));

        // R8: reset clears the output stage
        p_reset_clear_r8: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && result == '0));
    end
endmodule

bind cmp_bytematch_unit cmpu_checker #(
    .WIDTH   (WIDTH),
    .LANE_W  (LANE_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .comb_res  (comb_res),
    .result    (result),
    .out_valid (out_valid)
);

// File: tb/sim_cmp_bytematch_unit.sv
// Bench: drives a registered instance (u0) and a combinational instance (u1)
// with the same stimulus and compares both against bench reference functions.
module sim_cmp_bytematch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        cin = 1'b0;
    logic [31:0] r0, r1;
    logic        v0, v1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cmp_bytematch_unit #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(a), .opb(b), .cin(cin), .result(r0), .out_valid(v0)
    );

    cmp_bytematch_unit #(.OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(a), .opb(b), .cin(cin), .result(r1), .out_valid(v1)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] ref_calc(logic [1:0] o, logic [31:0] x,
                                             logic [31:0] y, logic c);
        logic [31:0] t;
        logic [31:0] m;
        t = y + ~x + 32'd1;
        case (o)
            2'b00: begin
                if (x[31] != y[31]) t[31] = y[31];
                return t;
            end
            2'b01: begin
                if (x[31] != y[31]) t[31] = x[31];
                return t;
            end
            2'b10: begin
                if (y == 32'hFFFF_FFFF && c) return 32'd1;
                return ((32'hFFFF_FFFF - x) < (y + {31'd0, c})) ? 32'd1 : 32'd0;
            end
            default: begin
                m = 32'hFF00_0000;
                for (int i = 0; i < 4; i++) begin
                    if ((x & m) == (y & m)) return 32'(i + 1);
                    m = m >> 8;
                end
                return 32'd0;
            end
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] o, logic [31:0] x,
                                     logic [31:0] y, logic [31:0] e);
        case (o)
            2'b00:   return (x[31] != y[31]) ? "R2" : "R1";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return (e == 32'd0) ? "R6" : "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge; comb due now, registered due one edge later.
    task automatic apply(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic c);
        logic [31:0] e;
        string       t;
        op = o; a = x; b = y; cin = c; in_valid = 1'b1;
        e = ref_calc(o, x, y, c);
        t = tag_of(o, x, y, e);
        #2;
        check(t, r1, e);
        check("R7 comb valid", {31'd0, v1}, 32'd1);
        @(negedge clk);
        check(t, r0, e);
        check("R7 reg valid", {31'd0, v0}, 32'd1);
    endtask

    logic [31:0] corners [4] = '{32'h0000_0000, 32'h7FFF_FFFF,
                                 32'h8000_0000, 32'hFFFF_FFFF};

    initial begin
        logic [31:0] held;
        logic [31:0] ra, rb, msk;
        int unused_seed;
        unused_seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        check("R8 reset result", r0, 32'd0);
        check("R8 reset valid", {31'd0, v0}, 32'd0);
        rst_n = 1'b1;

        // Directed corners: every pair, every opcode, both carry-ins.
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int o = 0; o < 4; o++) begin
                    apply(2'(o), corners[i], corners[j], 1'b0);
                    apply(2'(o), corners[i], corners[j], 1'b1);
                end

        // Directed byte search: R5 each lane, R6 no match.
        apply(2'b11, 32'h1122_3344, 32'h1100_0000, 1'b0);
        apply(2'b11, 32'h1122_3344, 32'h0022_0000, 1'b0);
        apply(2'b11, 32'h1122_3344, 32'h0000_3300, 1'b0);
        apply(2'b11, 32'h1122_3344, 32'h0000_0044, 1'b0);
        apply(2'b11, 32'h1122_3344, 32'h5566_7788, 1'b0);

        // R7 hold: drop in_valid, change operands, registered output holds.
        held = ref_calc(2'b11, 32'h1122_3344, 32'h5566_7788, 1'b0);
        in_valid = 1'b0; a = 32'h1234_5678; b = 32'h1234_5678; op = 2'b11;
        @(negedge clk);
        check("R7 hold result", r0, held);
        check("R7 hold valid", {31'd0, v0}, 32'd0);

        // Constrained random.
        for (int n = 0; n < 600; n++) begin
            ra  = ($urandom % 4 == 0) ? corners[$urandom % 4] : $urandom;
            rb  = ($urandom % 4 == 0) ? corners[$urandom % 4] : $urandom;
            msk = {{8{$urandom % 3 == 0}}, {8{$urandom % 3 == 0}},
                   {8{$urandom % 3 == 0}}, {8{$urandom % 3 == 0}}};
            rb  = (rb & ~msk) | (ra & msk);
            apply(2'($urandom % 4), ra, rb, 1'($urandom % 2));
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule